// File: doc/BRIEF.md
# CPU Address Router with Object-DMA Collision Handling

This block sits between an 8-bit CPU's 16-bit address bus and the memories and peripherals of the system. From the address it derives a single region select, produces the physical address the selected target should see, and drives the CPU read data from a packed set of per-region read buses. It is purely combinational except for one flag. That flag records whether the start-up code overlay still shadows the bottom of the cartridge ROM space.

The router also handles two special cases in the address map. A copy window repeats work RAM above the real work RAM. An object-DMA engine may hold either the external bus or the video bus. While it does, CPU reads that land on the busy bus see the byte the DMA is currently moving, and CPU writes there are dropped. A mode input selects between the colour and mono system variants, which differ in the pages the start-up overlay covers and in how far the external-bus collision reaches.

Top module: `cpu_addr_router`

## Requirements
- R1: Select bit order is 0 boot, 1 cartridge ROM, 2 cartridge RAM, 3 video RAM, 4 work RAM, 5 attribute memory, 6 I/O, 7 high RAM, 8 interrupt enable. Addresses 0x0000–0x7FFF select bit 1, 0x8000–0x9FFF bit 3, 0xA000–0xBFFF bit 2 and 0xC000–0xDFFF bit 4. `rdata_o` returns the byte in the selected slot of `reg_rdata_i` (slot k at bits 8k+7..8k).
- R2: After reset the overlay is on. While it is on, a read (not a write) of page 0x00 selects bit 0. In colour mode (`color_i`=1) reads of pages 0x02–0x08 also select bit 0. In mono mode those pages select ROM. An overlay hit takes priority over a DMA collision.
- R3: A write of any value to 0xFF50 turns the overlay off from the next clock until the next reset. A read of 0xFF50 selects nothing and returns 0xFF.
- R4: Addresses 0xE000–0xFDFF behave as 0xC000 plus address bits 12..0 for reads and writes: `addr_o` carries that address and work RAM is selected.
- R5: With `dma_active_i`=1 and `dma_bus_i`=0 (external), reads of 0x0000–0x7FFF return `dma_byte_i` with no select, and writes there assert no select and no `wr_o`.
- R6: In mono mode an external-bus collision also covers 0xA000–0xDFFF, including its echo window. In colour mode those addresses are unaffected.
- R7: With `dma_active_i`=1 and `dma_bus_i`=1 (video), reads of 0x8000–0x9FFF return `dma_byte_i` and writes there are dropped. Other regions are unaffected.
- R8: 0xFE00–0xFE9F selects attribute memory only while `dma_active_i`=0. While DMA is active, reads there return 0xFF and writes are dropped. Reads of 0xFEA0–0xFEFF return 0x00 with no select.
- R9: 0xFF00–0xFF7F (except 0xFF50) selects I/O, 0xFF80–0xFFFE selects high RAM, and 0xFFFF selects interrupt enable.
- R10: Writes to 0x0000–0x7FFF without a collision select cartridge ROM (its bank controller) with `wr_o`=1, even while the overlay is on. The boot select never accompanies a write.
- R11: At most one select bit is high. All selects are low when neither `cpu_rd_i` nor `cpu_wr_i` is high, and `wr_o` is high only with `cpu_wr_i` and a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rd_i | input | 1 | CPU read cycle |
| cpu_wr_i | input | 1 | CPU write cycle |
| color_i | input | 1 | 1 = colour variant, 0 = mono variant |
| dma_active_i | input | 1 | Object DMA is running |
| dma_bus_i | input | 1 | Bus held by DMA: 0 external, 1 video |
| dma_byte_i | input | 8 | Byte the DMA is currently moving |
| reg_rdata_i | input | 72 | Per-region read data, slot k at bits 8k+7..8k |
| sel_o | output | 9 | One-hot region select |
| wr_o | output | 1 | Write strobe to the selected region |
| addr_o | output | 16 | Address after echo mirroring |
| rdata_o | output | 8 | Read data to the CPU |

## Verification
The hardest state to reach is the overlay after it has been switched off. It cannot be switched back on except by reset, so every overlay check has to run before the 0xFF50 write. A later reset pulse then reopens it for a final look. The widest collision case also needs three conditions at once: mono mode, an external-bus DMA and an echo-window address. The directed sequence sets these up explicitly. A long pseudo-random phase then mixes modes, buses and DMA bytes against the bench's behavioural model every cycle.

// File: rtl/cpu_addr_router_pkg.sv
// Shared constants and types for the CPU address router.
// Assumes a 16-bit CPU address and one region select per target.
package cpu_addr_router_pkg;

    localparam int AW = 16;
    localparam int NREG = 9;

    // Region identifiers; the numeric value is the select bit position.
    typedef enum logic [3:0] {
        RG_BOOT = 4'd0,
        RG_CROM = 4'd1,
        RG_CRAM = 4'd2,
        RG_VRAM = 4'd3,
        RG_WRAM = 4'd4,
        RG_OAM  = 4'd5,
        RG_IO   = 4'd6,
        RG_HRAM = 4'd7,
        RG_IE   = 4'd8
    } region_e;

    // Bus the DMA engine may hold.
    typedef enum logic {
        BUS_EXT = 1'b0,
        BUS_VID = 1'b1
    } dma_bus_e;

    localparam logic [AW-1:0] OVERLAY_OFF_ADDR = 16'hFF50;
    localparam logic [7:0]    PAD_VALUE        = 8'h00;
    localparam logic [7:0]    OPEN_VALUE       = 8'hFF;

endpackage

// File: rtl/mm_region_decode.sv
// Address classifier: maps a CPU address to one region, applies echo
// mirroring and the start-up overlay. Assumes at most one of rd/wr.
module mm_region_decode
    import cpu_addr_router_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          color_i,
    input  logic          overlay_on_i,
    output region_e       cls_o,
    output logic          cls_valid_o,
    output logic          pad_hit_o,
    output logic          off_reg_hit_o,
    output logic [AW-1:0] eff_addr_o
);

    logic [7:0] page;
    logic       echo_hit;
    logic       overlay_page;

    // Detect the copy window and fold it down onto work RAM.
    always_comb begin
        echo_hit   = (addr_i >= 16'hE000) && (addr_i <= 16'hFDFF);
        eff_addr_o = echo_hit ? {3'b110, addr_i[12:0]} : addr_i;
        page       = eff_addr_o[15:8];
    end

    // Pages shadowed by the start-up overlay for the current variant.
    always_comb begin
        overlay_page = (page == 8'h00) ||
                       (color_i && (page >= 8'h02) && (page <= 8'h08));
    end

    // Classify the effective address into a region.
    always_comb begin
        cls_o         = RG_CROM;
        cls_valid_o   = 1'b1;
        pad_hit_o     = 1'b0;
        off_reg_hit_o = 1'b0;
        unique case (eff_addr_o[15:13])
            3'b000, 3'b001, 3'b010, 3'b011: begin
                if (overlay_on_i && rd_i && !wr_i && overlay_page)
                    cls_o = RG_BOOT;
                else
                    cls_o = RG_CROM;
            end
            3'b100: cls_o = RG_VRAM;
            3'b101: cls_o = RG_CRAM;
            3'b110: cls_o = RG_WRAM;
            default: begin
                if (page == 8'hFE) begin
                    if (eff_addr_o[7:0] < 8'hA0) begin
                        cls_o = RG_OAM;
                    end else begin
                        cls_valid_o = 1'b0;
                        pad_hit_o   = 1'b1;
                    end
                end else if (eff_addr_o == OVERLAY_OFF_ADDR) begin
                    cls_valid_o   = 1'b0;
                    off_reg_hit_o = 1'b1;
                end else if (!eff_addr_o[7]) begin
                    cls_o = RG_IO;
                end else if (eff_addr_o[7:0] == 8'hFF) begin
                    cls_o = RG_IE;
                end else begin
                    cls_o = RG_HRAM;
                end
            end
        endcase
    end

endmodule

// File: rtl/mm_dma_guard.sv
// Collision check: decides whether the CPU access to a region must be
// replaced by the DMA's byte (blocked) or simply refused (attribute
// memory while DMA runs). Assumes cls_i is meaningful only with valid_i.
module mm_dma_guard
    import cpu_addr_router_pkg::*;
(
    input  region_e  cls_i,
    input  logic     valid_i,
    input  logic     color_i,
    input  logic     dma_active_i,
    input  dma_bus_e dma_bus_i,
    output logic     blocked_o,
    output logic     refused_o
);

    logic ext_busy;
    logic vid_busy;

    // Which bus the DMA is currently holding.
    always_comb begin
        ext_busy = dma_active_i && (dma_bus_i == BUS_EXT);
        vid_busy = dma_active_i && (dma_bus_i == BUS_VID);
    end

    // Region-versus-bus collision rules.
    always_comb begin
        blocked_o = 1'b0;
        refused_o = 1'b0;
        if (valid_i) begin
            unique case (cls_i)
                RG_CROM:          blocked_o = ext_busy;
                RG_CRAM, RG_WRAM: blocked_o = ext_busy && !color_i;
                RG_VRAM:          blocked_o = vid_busy;
                RG_OAM:           refused_o = dma_active_i;
                default:          blocked_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mm_boot_latch.sv
// One-way overlay flag: set by reset, cleared by a CPU write to the
// overlay-off address, never set again until the next reset.
module mm_boot_latch
    import cpu_addr_router_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    output logic          overlay_on_o
);

    // Hold the overlay state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overlay_on_o <= 1'b1;
        else if (wr_i && (addr_i == OVERLAY_OFF_ADDR))
            overlay_on_o <= 1'b0;
    end

endmodule

// File: rtl/cpu_addr_router.sv
// Top of the CPU address router: combines decode, DMA guard and overlay
// latch, gates the one-hot selects and builds the CPU read data.
// Assumes the CPU never asserts read and write together.
module cpu_addr_router
    import cpu_addr_router_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr_i,
    input  logic               cpu_rd_i,
    input  logic               cpu_wr_i,
    input  logic               color_i,
    input  logic               dma_active_i,
    input  logic               dma_bus_i,
    input  logic [DW-1:0]      dma_byte_i,
    input  logic [NREG*DW-1:0] reg_rdata_i,
    output logic [NREG-1:0]    sel_o,
    output logic               wr_o,
    output logic [15:0]        addr_o,
    output logic [DW-1:0]      rdata_o
);

    region_e        cls;
    logic           cls_valid;
    logic           pad_hit;
    logic           off_hit;
    logic           blocked;
    logic           refused;
    logic           overlay_on;
    logic           access;
    logic [NREG-1:0] raw_sel;
    logic [DW-1:0]  terms [NREG];
    logic [DW-1:0]  mux_out;

    mm_boot_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (cpu_wr_i),
        .addr_i       (cpu_addr_i),
        .overlay_on_o (overlay_on)
    );

    mm_region_decode u_decode (
        .addr_i        (cpu_addr_i),
        .rd_i          (cpu_rd_i),
        .wr_i          (cpu_wr_i),
        .color_i       (color_i),
        .overlay_on_i  (overlay_on),
        .cls_o         (cls),
        .cls_valid_o   (cls_valid),
        .pad_hit_o     (pad_hit),
        .off_reg_hit_o (off_hit),
        .eff_addr_o    (addr_o)
    );

    mm_dma_guard u_guard (
        .cls_i        (cls),
        .valid_i      (cls_valid),
        .color_i      (color_i),
        .dma_active_i (dma_active_i),
        .dma_bus_i    (dma_bus_e'(dma_bus_i)),
        .blocked_o    (blocked),
        .refused_o    (refused)
    );

    // An access is in progress on either strobe.
    always_comb access = cpu_rd_i || cpu_wr_i;

    // Per-region select and read-data term, one slot per region.
    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign raw_sel[k] = cls_valid && (4'(cls) == 4'(k));
        assign sel_o[k]   = access && raw_sel[k] && !blocked && !refused;
        assign terms[k]   = {DW{sel_o[k]}} & reg_rdata_i[k*DW +: DW];
    end

    // OR together the gated read terms.
    always_comb begin
        mux_out = '0;
        for (int k = 0; k < NREG; k++) mux_out = mux_out | terms[k];
    end

    // Final read-data choice: DMA byte, pad zero, region data or open bus.
    always_comb begin
        if (blocked)
            rdata_o = dma_byte_i;
        else if (pad_hit)
            rdata_o = DW'(PAD_VALUE);
        else if (|sel_o)
            rdata_o = mux_out;
        else
            rdata_o = {DW{1'b1}};
    end

    // Write strobe to whichever region is selected.
    always_comb wr_o = cpu_wr_i && (|sel_o);

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R3
    overlay_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on);

    // R3
    overlay_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && cpu_addr_i == 16'hFF50) |=> !overlay_on);

    // R4
    echo_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && cpu_addr_i >= 16'hE000 && cpu_addr_i <= 16'hFDFF)
        |-> (addr_o[15:13] == 3'b110 && addr_o[12:0] == cpu_addr_i[12:0]));

    // R5
    ext_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && dma_active_i && !dma_bus_i && cpu_addr_i < 16'h8000)
        |-> !wr_o);

    // R7
    vid_read_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && !cpu_wr_i && dma_active_i && dma_bus_i &&
         cpu_addr_i >= 16'h8000 && cpu_addr_i < 16'hA000)
        |-> (rdata_o == dma_byte_i && sel_o == '0));

    // R10
    boot_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_i |-> !sel_o[0]);

endmodule

// File: tb/test_cpu_addr_router.sv
module test_cpu_addr_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic        rd = 1'b0, wr = 1'b0, col = 1'b1, act = 1'b0, bus = 1'b0;
    logic [7:0]  dbyte = 8'h00;
    logic [71:0] rdat;
    logic [8:0]  sel;
    logic        wro;
    logic [15:0] ao;
    logic [7:0]  rdo;

    int checks = 0;
    int errors = 0;
    bit mboot = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cpu_addr_router i_cpu_addr_router (
        .clk(clk), .rst_n(rst_n), .cpu_addr_i(a), .cpu_rd_i(rd), .cpu_wr_i(wr),
        .color_i(col), .dma_active_i(act), .dma_bus_i(bus), .dma_byte_i(dbyte),
        .reg_rdata_i(rdat), .sel_o(sel), .wr_o(wro), .addr_o(ao), .rdata_o(rdo)
    );

    function automatic logic [7:0] slot_val(int k);
        return 8'h31 + 8'(8'h11 * k);
    endfunction

    initial for (int k = 0; k < 9; k++) rdat[k*8 +: 8] = slot_val(k);

    // Behavioural overlay flag.
    always @(posedge clk) begin
        if (!rst_n) mboot <= 1'b1;
        else if (wr && a == 16'hFF50) mboot <= 1'b0;
    end

    // Reference model of the address map.
    task automatic model(output logic [8:0] es, output logic ew,
                         output logic [15:0] ea, output logic [7:0] ed,
                         output string tag);
        int idx;
        int eff;
        bit ext, vid;
        idx = -1; ed = 8'hFF; tag = "R1";
        ext = act && !bus; vid = act && bus;
        eff = a;
        if (a >= 16'hE000 && a <= 16'hFDFF) begin
            eff = 16'hC000 + (a % 16'h2000); tag = "R4";
        end
        ea = 16'(eff);
        if (rd && !wr && mboot &&
            ((eff / 256) == 0 || (col && (eff / 256) >= 2 && (eff / 256) <= 8))) begin
            idx = 0; tag = "R2";
        end else if (eff < 16'h8000) begin
            if (ext) begin ed = dbyte; tag = "R5"; end
            else begin idx = 1; if (wr) tag = "R10"; end
        end else if (eff < 16'hA000) begin
            if (vid) begin ed = dbyte; tag = "R7"; end else idx = 3;
        end else if (eff < 16'hE000) begin
            if (ext && !col) begin ed = dbyte; tag = "R6"; end
            else idx = (eff < 16'hC000) ? 2 : 4;
        end else if (eff < 16'hFEA0) begin
            tag = "R8";
            if (!act) idx = 5;
        end else if (eff < 16'hFF00) begin
            tag = "R8"; ed = 8'h00;
        end else if (eff == 16'hFF50) begin
            tag = "R3";
        end else begin
            tag = "R9";
            if (eff < 16'hFF80) idx = 6;
            else if (eff < 16'hFFFF) idx = 7;
            else idx = 8;
        end
        if (!(rd || wr)) begin idx = -1; tag = "R11"; end
        es = (idx >= 0) ? (9'b1 << idx) : 9'b0;
        if (idx >= 0) ed = slot_val(idx);
        ew = wr && (idx >= 0);
    endtask

    task automatic step(input logic [15:0] ad, input logic r, input logic w,
                        input logic ac, input logic b, input logic [7:0] db,
                        input logic c);
        logic [8:0] es; logic ew; logic [15:0] ea; logic [7:0] ed; string tag;
        @(negedge clk);
        a = ad; rd = r; wr = w; act = ac; bus = b; dbyte = db; col = c;
        #5;
        model(es, ew, ea, ed, tag);
        checks++;
        if (sel !== es || wro !== ew || ao !== ea || (r && !w && rdo !== ed)) begin
            errors++;
            $display("FAIL %s addr=%h sel=%b/%b wr=%b/%b addr_o=%h/%h rdata=%h/%h",
                     tag, ad, sel, es, wro, ew, ao, ea, rdo, ed);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rd = 1'b0; wr = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; idle(3); @(negedge clk); rst_n = 1'b1;
        // R2 reset state and overlay pages
        step(16'h0000, 1, 0, 0, 0, 8'h00, 1);
        step(16'h0005, 1, 0, 0, 0, 8'h00, 0);
        step(16'h0200, 1, 0, 0, 0, 8'h00, 1);
        step(16'h0200, 1, 0, 0, 0, 8'h00, 0);
        step(16'h08FF, 1, 0, 0, 0, 8'h00, 1);
        step(16'h0100, 1, 0, 0, 0, 8'h00, 1);
        step(16'h0010, 1, 0, 1, 0, 8'hC3, 1);
        // R10 writes reach the bank controller
        step(16'h0000, 0, 1, 0, 0, 8'h00, 1);
        step(16'h2100, 0, 1, 0, 0, 8'h00, 0);
        // R1 plain regions
        step(16'h4000, 1, 0, 0, 0, 8'h00, 1);
        step(16'h8000, 1, 0, 0, 0, 8'h00, 1);
        step(16'hA000, 1, 0, 0, 0, 8'h00, 1);
        step(16'hC000, 1, 0, 0, 0, 8'h00, 1);
        step(16'hD123, 0, 1, 0, 0, 8'h00, 0);
        // R4 echo window
        step(16'hE123, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFDFF, 0, 1, 0, 0, 8'h00, 0);
        // R5 external collision
        step(16'h1234, 1, 0, 1, 0, 8'h5A, 1);
        step(16'h7FFF, 0, 1, 1, 0, 8'h5A, 1);
        // R6 mono widening, colour unaffected
        step(16'hA000, 1, 0, 1, 0, 8'h96, 0);
        step(16'hC100, 0, 1, 1, 0, 8'h96, 0);
        step(16'hE010, 1, 0, 1, 0, 8'h69, 0);
        step(16'hA000, 1, 0, 1, 0, 8'h96, 1);
        // R7 video collision
        step(16'h8800, 1, 0, 1, 1, 8'hE1, 1);
        step(16'h9FFF, 0, 1, 1, 1, 8'hE1, 1);
        step(16'h4100, 1, 0, 1, 1, 8'hE1, 1);
        // R8 attribute memory and pad
        step(16'hFE00, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFE9F, 1, 0, 1, 1, 8'h22, 1);
        step(16'hFE40, 0, 1, 1, 0, 8'h22, 1);
        step(16'hFEA0, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFEFF, 0, 1, 0, 0, 8'h00, 1);
        // R9 top page
        step(16'hFF00, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFF80, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFFFE, 0, 1, 0, 0, 8'h00, 1);
        step(16'hFFFF, 1, 0, 0, 0, 8'h00, 1);
        // R11 no strobe
        step(16'h0000, 0, 0, 0, 0, 8'h00, 1);
        // R3 overlay switch-off
        step(16'hFF50, 1, 0, 0, 0, 8'h00, 1);
        step(16'hFF50, 0, 1, 0, 0, 8'h00, 1);
        step(16'h0000, 1, 0, 0, 0, 8'h00, 1);
        step(16'h0300, 1, 0, 0, 0, 8'h00, 1);
        // mixed pseudo-random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ad;
            int pick;
            pick = int'($urandom % 6);
            ad = 16'($urandom);
            if (pick == 0) ad = 16'hFE00 | 16'(ad[7:0]);
            if (pick == 1) ad = 16'hFF00 | 16'(ad[7:0]);
            if (pick == 2) ad = {8'h00, ad[7:0]} + 16'(16'h100 * ($urandom % 10));
            if (i == 1500) begin
                rst_n = 1'b0; idle(2); @(negedge clk); rst_n = 1'b1;
            end
            step(ad, ($urandom % 3) == 0, ($urandom % 3) == 1, $urandom % 2,
                 $urandom % 2, 8'($urandom), $urandom % 2);
        end
        // R2 overlay back after reset
        rst_n = 1'b0; idle(2); @(negedge clk); rst_n = 1'b1;
        step(16'h0042, 1, 0, 0, 0, 8'h00, 1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule